// File: doc/BRIEF.md
# External Interrupt Source Router

The router watches a small bank of external interrupt request pins (twelve by default) and turns them into three kinds of request: a normal core interrupt line, a critical interrupt line, and a pin that passes requests on to an outside controller. Each source has its own configuration. Polarity and detection mode are set per source, so the same input can be read as active-low, active-high, falling-edge or rising-edge. Each source also has a mask, a 4-bit priority, a 16-bit vector and a 2-bit route.

Edge-detected sources hold a pending flag until an acknowledge read takes them. Level-detected sources are pending for as long as the pin stays active. For the core line, a combinational arbiter picks the highest-priority eligible source. A read of the acknowledge register returns that source's vector, or a programmable spurious vector when no source is eligible.

A single-cycle register port configures the block. Writes take effect on the next clock edge. Read data is registered and appears one cycle after the read strobe.

Top module: `ext_irq_router`

Register map (word addresses): source *i* has its configuration word at 2*i* and its route word at 2*i*+1. The spurious vector is at 2*N*, and the acknowledge register at 2*N*+1 (N = number of sources). The acknowledge register is read-only; writes to it are ignored.

Configuration word layout:
- bits 15:0 hold the vector;
- bits 19:16 hold the priority;
- bit 24 is polarity;
- bit 25 is sense;
- bit 31 is mask;
- all other bits read as zero.

Route word layout: bit 0 sends the source to the external pin, bit 1 sends it to the critical line, and the other bits read as zero. Route value 0 means the core line.

## Requirements
- R1: After reset every configuration field is zero, the spurious vector is 0xFFFF, read data is zero, and all three interrupt outputs are low.
- R2: Polarity bit 24 selects the active state. A value of 0 means active-low (level) or falling edge (edge). A value of 1 means active-high (level) or rising edge (edge).
- R3: With sense bit 25 at 0 the source is edge-detected. The configured edge sets pending, the opposite edge does not, and pending stays set after the pin returns inactive.
- R4: With sense bit 25 at 1 the source is pending exactly while its synchronized pin is active.
- R5: Among eligible core-routed sources, the acknowledge read returns the vector of the highest priority source (15 highest, 0 lowest). On a tie, the lowest-numbered source wins. core_irq_o is high whenever an eligible source exists.
- R6: An acknowledge read clears the pending flag of the selected edge-detected source. It does not clear a level-detected source that is still active.
- R7: Mask bit 31 removes a source from core-line arbitration only. A masked source routed to the critical line still drives it.
- R8: A source with priority 0 never asserts core_irq_o and is never returned by an acknowledge read.
- R9: A level-detected source with route value 2 drives crit_irq_o, and one with route value 1 drives irq_out_o. Neither reaches the core line.
- R10: An edge-detected source routed to the critical line or the external pin drives no output. A source with route value 3 drives no output.
- R11: An acknowledge read with no eligible source returns the spurious vector, which is programmable at address 2N.
- R12: Configuration and route words read back the written fields at the stated bit positions, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin_i | input | NUM_SRC | Asynchronous external request pins |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after reg_rd_i |
| core_irq_o | output | 1 | Normal core interrupt request |
| crit_irq_o | output | 1 | Critical interrupt request |
| irq_out_o | output | 1 | Request passed to an external controller |

## Verification
On every cycle, the assertions check these properties:
- route exclusivity: no source feeds two outputs at once;
- the arbiter never selects a priority-0 source or a source that is not eligible;
- a core request exists only when the arbiter has found one;
- an acknowledge with nothing eligible returns the spurious vector;
- the critical line is raised only after a critical-routed request;
- the outputs are quiet following reset.

Only the directed scenarios can show the following:
- the polarity and edge-versus-level semantics as seen at the pins;
- tie-breaking by index and the effect of the mask and priority on the acknowledged vector;
- that an acknowledge clears an edge source but not an active level source;
- the exact register bit layout.

// File: rtl/eirq_pkg.sv
// Package: shared constants and types for the external interrupt router.
// Assumes a 32-bit register data path and the fixed field layout below.
package eirq_pkg;
    localparam int DATA_W    = 32;
    localparam int VEC_W     = 16;
    localparam int PRIO_W    = 4;
    localparam int PRIO_LSB  = 16;
    localparam int POL_BIT   = 24;
    localparam int SENSE_BIT = 25;
    localparam int MASK_BIT  = 31;

    typedef enum logic [1:0] {
        DEST_CORE = 2'b00,
        DEST_PIN  = 2'b01,
        DEST_CRIT = 2'b10,
        DEST_NONE = 2'b11
    } dest_e;

    typedef struct packed {
        logic              mask;
        logic              sense;
        logic              pol;
        logic [PRIO_W-1:0] prio;
        logic [VEC_W-1:0]  vec;
        dest_e             dest;
    } src_cfg_t;

    // Packs a configuration into its register word.
    function automatic logic [DATA_W-1:0] cfg_to_word(input src_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[VEC_W-1:0]                 = c.vec;
        w[PRIO_LSB +: PRIO_W]        = c.prio;
        w[POL_BIT]                   = c.pol;
        w[SENSE_BIT]                 = c.sense;
        w[MASK_BIT]                  = c.mask;
        return w;
    endfunction
endpackage

// File: rtl/eirq_src_ctrl.sv
// One interrupt source: synchronises its pin, qualifies it by polarity and
// sense, keeps the edge pending flag and splits the request by route.
// Assumes the pin is asynchronous and the ack strobe is one cycle wide.
module eirq_src_ctrl
    import eirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin_i,
    input  src_cfg_t cfg_i,
    input  logic     ack_i,
    output logic     core_req_o,
    output logic     crit_req_o,
    output logic     pin_req_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   edge_pend_q;
    logic                   synced;
    logic                   active;
    logic                   edge_hit;
    logic                   pending;

    assign synced = sync_q[SYNC_STAGES-1];

    // Pin synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= pin_i;
            for (int k = 1; k < SYNC_STAGES; k++) begin
                sync_q[k] <= sync_q[k-1];
            end
        end
    end

    // Previous synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= synced;
    end

    // Polarity and edge qualification.
    always_comb begin
        active   = cfg_i.pol ? synced : ~synced;
        edge_hit = cfg_i.pol ? (synced & ~prev_q) : (~synced & prev_q);
    end

    // Edge pending latch: a new edge wins over a same-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)             edge_pend_q <= 1'b0;
        else if (cfg_i.sense)   edge_pend_q <= 1'b0;
        else if (edge_hit)      edge_pend_q <= 1'b1;
        else if (ack_i)         edge_pend_q <= 1'b0;
    end

    // Route the pending state to one destination.
    always_comb begin
        pending    = cfg_i.sense ? active : edge_pend_q;
        core_req_o = pending && (cfg_i.dest == DEST_CORE) && !cfg_i.mask
                     && (cfg_i.prio != '0);
        crit_req_o = cfg_i.sense && active && (cfg_i.dest == DEST_CRIT);
        pin_req_o  = cfg_i.sense && active && (cfg_i.dest == DEST_PIN);
    end
endmodule

// File: rtl/eirq_prio_arb.sv
// Combinational priority selector over the core-line requests.
// Picks the strictly highest priority; the scan order favours low indices.
module eirq_prio_arb
    import eirq_pkg::*;
#(
    parameter int NUM_SRC = 12,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_SRC-1:0]             req_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    output logic                           valid_o,
    output logic [IDX_W-1:0]               idx_o,
    output logic [PRIO_W-1:0]              prio_o
);
    // Linear scan with strict compare keeps the first of equal priorities.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req_i[i] && (!valid_o || (prio_i[i] > prio_o))) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
                prio_o  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/eirq_cfg_regs.sv
// Configuration storage and read mux for all sources and the spurious
// vector. Assumes word addresses; the acknowledge address is handled above.
module eirq_cfg_regs
    import eirq_pkg::*;
#(
    parameter int              NUM_SRC    = 12,
    parameter int              ADDR_W     = 5,
    parameter logic [VEC_W-1:0] SPUR_RESET = 16'hFFFF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output src_cfg_t [NUM_SRC-1:0]  cfg_o,
    output logic [VEC_W-1:0]        spur_o,
    output logic [DATA_W-1:0]       rdata_o
);
    localparam int AIDX_W    = ADDR_W - 1;
    localparam int SPUR_ADDR = 2 * NUM_SRC;

    logic [AIDX_W-1:0] word_idx;
    logic              is_dest;

    assign word_idx = addr_i[ADDR_W-1:1];
    assign is_dest  = addr_i[0];

    // Per-source configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o <= '0;
        end else if (wr_i) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (word_idx == AIDX_W'(i)) begin
                    if (is_dest) begin
                        cfg_o[i].dest <= dest_e'(wdata_i[1:0]);
                    end else begin
                        cfg_o[i].vec   <= wdata_i[VEC_W-1:0];
                        cfg_o[i].prio  <= wdata_i[PRIO_LSB +: PRIO_W];
                        cfg_o[i].pol   <= wdata_i[POL_BIT];
                        cfg_o[i].sense <= wdata_i[SENSE_BIT];
                        cfg_o[i].mask  <= wdata_i[MASK_BIT];
                    end
                end
            end
        end
    end

    // Spurious vector register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         spur_o <= SPUR_RESET;
        else if (wr_i && addr_i == ADDR_W'(SPUR_ADDR))      spur_o <= wdata_i[VEC_W-1:0];
    end

    // Read mux for configuration, route and spurious words.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (word_idx == AIDX_W'(i)) begin
                rdata_o = is_dest ? {{(DATA_W-2){1'b0}}, cfg_o[i].dest}
                                  : cfg_to_word(cfg_o[i]);
            end
        end
        if (addr_i == ADDR_W'(SPUR_ADDR)) begin
            rdata_o = {{(DATA_W-VEC_W){1'b0}}, spur_o};
        end
    end
endmodule

// File: rtl/ext_irq_router.sv
// Top of the external interrupt router: per-source control, core-line
// arbitration, acknowledge handling and registered outputs.
// Assumes reg_rd_i and reg_wr_i are single-cycle strobes.
module ext_irq_router
    import eirq_pkg::*;
#(
    parameter int               NUM_SRC     = 12,
    parameter int               SYNC_STAGES = 2,
    parameter logic [15:0]      SPUR_RESET  = 16'hFFFF,
    parameter int               ADDR_W      = $clog2(2 * NUM_SRC + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_pin_i,
    input  logic               reg_wr_i,
    input  logic               reg_rd_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    output logic               core_irq_o,
    output logic               crit_irq_o,
    output logic               irq_out_o
);
    localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int ACK_ADDR = 2 * NUM_SRC + 1;

    src_cfg_t [NUM_SRC-1:0]             cfg;
    logic [VEC_W-1:0]                   spur_vec;
    logic [DATA_W-1:0]                  regs_rdata;
    logic [NUM_SRC-1:0]                 core_req;
    logic [NUM_SRC-1:0]                 crit_req;
    logic [NUM_SRC-1:0]                 pin_req;
    logic [NUM_SRC-1:0]                 ack_sel;
    logic [NUM_SRC-1:0][PRIO_W-1:0]     prio_vec;
    logic                               arb_valid;
    logic [IDX_W-1:0]                   arb_idx;
    logic [PRIO_W-1:0]                  arb_prio;
    logic                               ack_hit;
    logic [VEC_W-1:0]                   ack_vec;

    eirq_cfg_regs #(
        .NUM_SRC    (NUM_SRC),
        .ADDR_W     (ADDR_W),
        .SPUR_RESET (SPUR_RESET)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .cfg_o   (cfg),
        .spur_o  (spur_vec),
        .rdata_o (regs_rdata)
    );

    assign ack_hit = reg_rd_i && (reg_addr_i == ADDR_W'(ACK_ADDR));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign prio_vec[g] = cfg[g].prio;
        assign ack_sel[g]  = ack_hit && arb_valid && (arb_idx == IDX_W'(g));

        eirq_src_ctrl #(
            .SYNC_STAGES (SYNC_STAGES)
        ) src_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_i      (irq_pin_i[g]),
            .cfg_i      (cfg[g]),
            .ack_i      (ack_sel[g]),
            .core_req_o (core_req[g]),
            .crit_req_o (crit_req[g]),
            .pin_req_o  (pin_req[g])
        );
    end

    eirq_prio_arb #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) arb_i (
        .req_i   (core_req),
        .prio_i  (prio_vec),
        .valid_o (arb_valid),
        .idx_o   (arb_idx),
        .prio_o  (arb_prio)
    );

    // Vector of the winning source, or the spurious vector.
    always_comb begin
        ack_vec = spur_vec;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (arb_valid && arb_idx == IDX_W'(i)) ack_vec = cfg[i].vec;
        end
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)        reg_rdata_o <= '0;
        else if (reg_rd_i) reg_rdata_o <= ack_hit ? {{(DATA_W-VEC_W){1'b0}}, ack_vec}
                                                  : regs_rdata;
    end

    // Registered interrupt outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_irq_o <= 1'b0;
            crit_irq_o <= 1'b0;
            irq_out_o  <= 1'b0;
        end else begin
            core_irq_o <= arb_valid;
            crit_irq_o <= |crit_req;
            irq_out_o  <= |pin_req;
        end
    end
endmodule

// File: rtl/ext_irq_router_chk.sv
// Checker for the external interrupt router, bound to the top module.
module ext_irq_router_chk #(
    parameter int NUM_SRC = 12,
    parameter int ADDR_W  = 5,
    parameter int IDX_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_rd_i,
    input logic [ADDR_W-1:0]  reg_addr_i,
    input logic [31:0]        reg_rdata_o,
    input logic               core_irq_o,
    input logic               crit_irq_o,
    input logic               irq_out_o,
    input logic [NUM_SRC-1:0] core_req,
    input logic [NUM_SRC-1:0] crit_req,
    input logic [NUM_SRC-1:0] pin_req,
    input logic               arb_valid,
    input logic [IDX_W-1:0]   arb_idx,
    input logic [3:0]         arb_prio,
    input logic [15:0]        spur_vec
);
    localparam int ACK_ADDR = 2 * NUM_SRC + 1;

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!core_irq_o && !crit_irq_o && !irq_out_o && reg_rdata_o == '0));

    p_core_from_winner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        core_irq_o |-> $past(arb_valid));

    p_any_request_found_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_valid |-> (core_req == '0));

    p_winner_eligible_r8: assert property (@(posedge clk) disable iff (!rst_n)
        arb_valid |-> (core_req[arb_idx] && arb_prio != 4'd0));

    p_route_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((crit_req & pin_req) == '0) && ((crit_req & core_req) == '0)
        && ((pin_req & core_req) == '0));

    p_crit_from_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        crit_irq_o |-> $past(|crit_req));

    p_spurious_on_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == ADDR_W'(ACK_ADDR) && !arb_valid)
        |=> (reg_rdata_o == {16'h0, $past(spur_vec)}));
endmodule

bind ext_irq_router ext_irq_router_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o),
    .core_irq_o  (core_irq_o),
    .crit_irq_o  (crit_irq_o),
    .irq_out_o   (irq_out_o),
    .core_req    (core_req),
    .crit_req    (crit_req),
    .pin_req     (pin_req),
    .arb_valid   (arb_valid),
    .arb_idx     (arb_idx),
    .arb_prio    (arb_prio),
    .spur_vec    (spur_vec)
);

// File: tb/ext_irq_router_tb_top.sv
`timescale 1ns/1ps
module ext_irq_router_tb_top;
    localparam int N    = 12;
    localparam int AW   = 5;
    localparam int SPUR = 2 * N;
    localparam int ACK  = 2 * N + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pins = '0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          core_irq;
    logic          crit_irq;
    logic          irq_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ext_irq_router dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_pin_i   (pins),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .core_irq_o  (core_irq),
        .crit_irq_o  (crit_irq),
        .irq_out_o   (irq_out)
    );

    function automatic logic [31:0] cfgw(input logic [15:0] vec, input logic [3:0] prio,
                                         input logic pol, input logic sense, input logic mask);
        return {mask, 5'b0, sense, pol, 4'b0, prio, vec};
    endfunction

    function automatic int cfg_a(input int i); return 2 * i;     endfunction
    function automatic int dst_a(input int i); return 2 * i + 1; endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        pins = '0; wr = 1'b0; rd = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic reg_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_rd(input int a, output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = AW'(a);
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        check("R1 core", {31'b0, core_irq}, 0);
        check("R1 crit", {31'b0, crit_irq}, 0);
        check("R1 irq_out", {31'b0, irq_out}, 0);
        check("R1 rdata", rdata, 0);
        reg_rd(cfg_a(3), d); check("R1 cfg zero", d, 0);
        reg_rd(SPUR, d);     check("R1 spurious reset", d, 32'h0000_FFFF);
        reg_rd(ACK, d);      check("R11 empty ack", d, 32'h0000_FFFF);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        do_reset();
        reg_wr(cfg_a(0), cfgw(16'h1234, 4'd5, 1'b1, 1'b1, 1'b0));
        reg_rd(cfg_a(0), d); check("R12 cfg fields", d, 32'h0305_1234);
        reg_wr(cfg_a(1), 32'hFFFF_FFFF);
        reg_rd(cfg_a(1), d); check("R12 cfg reserved zero", d, 32'h830F_FFFF);
        reg_wr(dst_a(1), 32'hFFFF_FFFF);
        reg_rd(dst_a(1), d); check("R12 route word", d, 32'h0000_0003);
    endtask

    task automatic t_level();
        logic [31:0] d;
        do_reset();
        reg_wr(cfg_a(0), cfgw(16'h1234, 4'd5, 1'b1, 1'b1, 1'b0));
        pins[0] = 1'b1; settle();
        check("R4 level high pending", {31'b0, core_irq}, 1);
        reg_rd(ACK, d); check("R5 level vector", d, 32'h0000_1234);
        settle();
        check("R6 level stays after ack", {31'b0, core_irq}, 1);
        pins[0] = 1'b0; settle();
        check("R4 level drops", {31'b0, core_irq}, 0);
        // Active-low level source.
        pins[2] = 1'b1; settle();
        reg_wr(cfg_a(2), cfgw(16'h0222, 4'd5, 1'b0, 1'b1, 1'b0));
        settle();
        check("R2 low-active idle high", {31'b0, core_irq}, 0);
        pins[2] = 1'b0; settle();
        check("R2 low-active asserted", {31'b0, core_irq}, 1);
        reg_rd(ACK, d); check("R2 low-active vector", d, 32'h0000_0222);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        do_reset();
        reg_wr(cfg_a(3), cfgw(16'h0333, 4'd7, 1'b1, 1'b0, 1'b0));
        pins[3] = 1'b1; repeat (2) @(negedge clk);
        pins[3] = 1'b0; settle();
        check("R3 rising latched", {31'b0, core_irq}, 1);
        reg_rd(ACK, d); check("R3 edge vector", d, 32'h0000_0333);
        settle();
        check("R6 edge cleared by ack", {31'b0, core_irq}, 0);
        reg_rd(ACK, d); check("R6 second ack spurious", d, 32'h0000_FFFF);
        reg_wr(cfg_a(4), cfgw(16'h0444, 4'd7, 1'b0, 1'b0, 1'b0));
        pins[4] = 1'b1; settle();
        check("R3 rising ignored for falling", {31'b0, core_irq}, 0);
        pins[4] = 1'b0; settle();
        check("R3 falling latched", {31'b0, core_irq}, 1);
        reg_rd(ACK, d); check("R3 falling vector", d, 32'h0000_0444);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        do_reset();
        reg_wr(cfg_a(1), cfgw(16'h0011, 4'd3, 1'b1, 1'b1, 1'b0));
        reg_wr(cfg_a(5), cfgw(16'h0055, 4'd9, 1'b1, 1'b1, 1'b0));
        reg_wr(cfg_a(6), cfgw(16'h0066, 4'd9, 1'b1, 1'b1, 1'b0));
        reg_wr(cfg_a(7), cfgw(16'h0077, 4'd2, 1'b1, 1'b1, 1'b0));
        pins[1] = 1'b1; pins[5] = 1'b1; pins[6] = 1'b1; pins[7] = 1'b1;
        settle();
        reg_rd(ACK, d); check("R5 tie lowest index", d, 32'h0000_0055);
        reg_wr(cfg_a(5), cfgw(16'h0055, 4'd9, 1'b1, 1'b1, 1'b1));
        reg_rd(ACK, d); check("R7 masked skipped", d, 32'h0000_0066);
        reg_wr(cfg_a(1), cfgw(16'h0011, 4'd15, 1'b1, 1'b1, 1'b0));
        reg_rd(ACK, d); check("R5 highest priority", d, 32'h0000_0011);
    endtask

    task automatic t_mask_prio0();
        logic [31:0] d;
        do_reset();
        reg_wr(cfg_a(0), cfgw(16'h0100, 4'd4, 1'b1, 1'b1, 1'b1));
        pins[0] = 1'b1; settle();
        check("R7 masked no core", {31'b0, core_irq}, 0);
        reg_rd(ACK, d); check("R7 masked ack spurious", d, 32'h0000_FFFF);
        reg_wr(cfg_a(0), cfgw(16'h0100, 4'd0, 1'b1, 1'b1, 1'b0));
        settle();
        check("R8 prio0 no core", {31'b0, core_irq}, 0);
        reg_rd(ACK, d); check("R8 prio0 ack spurious", d, 32'h0000_FFFF);
        reg_wr(cfg_a(8), cfgw(16'h0800, 4'd4, 1'b1, 1'b1, 1'b1));
        reg_wr(dst_a(8), 32'h2);
        pins[8] = 1'b1; settle();
        check("R7 masked still critical", {31'b0, crit_irq}, 1);
    endtask

    task automatic t_routes();
        logic [31:0] d;
        do_reset();
        reg_wr(cfg_a(9), cfgw(16'h0900, 4'd6, 1'b1, 1'b1, 1'b0));
        reg_wr(dst_a(9), 32'h1);
        pins[9] = 1'b1; settle();
        check("R9 pin route out", {31'b0, irq_out}, 1);
        check("R9 pin route no core", {31'b0, core_irq}, 0);
        check("R9 pin route no crit", {31'b0, crit_irq}, 0);
        reg_wr(cfg_a(10), cfgw(16'h0A00, 4'd6, 1'b1, 1'b1, 1'b0));
        reg_wr(dst_a(10), 32'h2);
        pins[10] = 1'b1; settle();
        check("R9 crit route", {31'b0, crit_irq}, 1);
        pins[9] = 1'b0; pins[10] = 1'b0; settle();
        check("R9 routes drop", {30'b0, crit_irq, irq_out}, 0);
        // Edge source routed to critical goes nowhere.
        reg_wr(cfg_a(11), cfgw(16'h0B00, 4'd6, 1'b1, 1'b0, 1'b0));
        reg_wr(dst_a(11), 32'h2);
        pins[11] = 1'b1; settle();
        check("R10 edge crit nowhere", {29'b0, core_irq, crit_irq, irq_out}, 0);
        pins[11] = 1'b0;
        reg_wr(cfg_a(11), cfgw(16'h0B00, 4'd6, 1'b1, 1'b1, 1'b0));
        reg_wr(dst_a(11), 32'h3);
        pins[11] = 1'b1; settle();
        check("R10 both bits nowhere", {29'b0, core_irq, crit_irq, irq_out}, 0);
        reg_wr(SPUR, 32'h0000_BEEF);
        reg_rd(SPUR, d); check("R11 spurious readback", d, 32'h0000_BEEF);
        reg_rd(ACK, d);  check("R11 programmed spurious", d, 32'h0000_BEEF);
    endtask

    initial begin
        t_reset();
        t_regmap();
        t_level();
        t_edge();
        t_priority();
        t_mask_prio0();
        t_routes();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule